// File: doc/BRIEF.md
# Byte-Serial Peripheral Port with Fault and Collision Flags

This block is an SPI port for a small processor bus. It shifts frames of one byte either as master or as slave. The processor reaches it through four byte-wide registers. A control register enables the port, picks master or slave and gates the interrupt. A status register holds the flags and three pin-option bits. A transmit register is write-only, and a receive register is read-only and returns a one-byte buffer. The clock mode is fixed: SCK idles low, data is sampled on the rising edge and changes on the falling edge, and frames go MSB first. In master mode each SCK half-period lasts `HALF_DIV` system clocks. In slave mode SCK, MOSI and the slave-select pin pass through a synchronizer, and the external master must hold each SCK level for several system clocks.

Software reacts to the completion flag or to the interrupt. Every error and completion flag except the mode fault is cleared by the same two-step access: first the status register, then the data registers. Between the two steps no other register access may take place. The mode fault has its own clearing pair. When the port is a master and a slave-select is seen, the port gives up the bus. Slave select can come from the pin or from a status bit that software drives. The data output can be released by software.

Top module: `spi_byte_port`

## Requirements
- R1: Register map: address 0 is control (bit0 enable, bit1 master, bit2 interrupt enable, other bits read 0), address 1 is status, address 2 is transmit (reads 0) and address 3 is receive. In master mode, writing transmit while idle with the completion flag at 0 sends the byte MSB first on MOSI. SCK idles low and each half-period is HALF_DIV clocks. MISO is sampled on each rising SCK edge, and the received byte is readable at address 3.
- R2: Status bit7 (completion) sets when a frame finishes. irq_o is high while control bit2 is 1 and status bit7 or bit4 is 1.
- R3: A status access, read or write, followed directly by a receive read or a transmit write clears status bits 7, 6 and 5. Any other access placed between the two steps cancels the clearing.
- R4: A transmit write made while status bit7 is 1 is ignored: no frame starts and no flag changes.
- R5: A transmit write made during a frame sets status bit6 (collision). The write is dropped, and the running frame goes on unchanged.
- R6: If a frame finishes while status bit7 is still 1, status bit5 (overrun) sets and the receive register keeps the older byte.
- R7: In master mode with the port enabled, a low effective slave select sets status bit4 (mode fault). It also clears control bit1, turns off sck_oe, mosi_oe and miso_oe, and raises irq_o when control bit2 is 1.
- R8: Status bit4 clears only when a status access made while bit4 is 1 is followed directly by a control write.
- R9: Status bit2 at 1 drops mosi_oe in master mode and miso_oe in slave mode. SCK stays driven in master mode.
- R10: With status bit1 at 1, the slave-select pin is ignored and status bit0 acts as an active-low select. At 1, that bit deselects the slave: SCK pulses are ignored and miso_oe stays 0.
- R11: As a selected slave, the port shifts the byte loaded through address 2 out on MISO, MSB first, and stores the byte taken from MOSI.
- R12: After reset the control, status and receive registers read 00h, irq_o is 0, and every output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq_o | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from an external master |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for sck_o |
| mosi_i | input | 1 | Serial data in, slave mode |
| mosi_o | output | 1 | Serial data out, master mode |
| mosi_oe | output | 1 | Output enable for mosi_o |
| miso_i | input | 1 | Serial data in, master mode |
| miso_o | output | 1 | Serial data out, slave mode |
| miso_oe | output | 1 | Output enable for miso_o |
| ss_n_i | input | 1 | Slave-select pin, active low |

## Verification
The bench uses the default parameters: 8-bit frames, HALF_DIV of 4 and a two-stage synchronizer. With these values a master frame lasts 64 clocks, so a table of patterns fits easily into the run, and loopback with optional inversion gives each pattern a known received byte. The short synchronizer latency lets the bench drive slave SCK with half-periods of six clocks. Collisions, overrun, broken clearing sequences and mode faults can then be placed at exact points inside a frame.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_TXD  = 2'd2,
        A_RXD  = 2'd3
    } addr_e;

    typedef struct packed {
        logic [4:0] rsvd;
        logic       ie;
        logic       mst;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic done;
        logic wcol;
        logic ovr;
        logic modf;
    } flags_t;

    typedef struct packed {
        logic sod;
        logic ssm;
        logic ssi;
    } pinsel_t;

    function automatic logic [REG_W-1:0] stat_word(flags_t f, pinsel_t p);
        return {f.done, f.wcol, f.ovr, f.modf, 1'b0, p.sod, p.ssm, p.ssi};
    endfunction

    function automatic ctrl_t ctrl_from_bus(logic [REG_W-1:0] w);
        ctrl_t c;
        c      = ctrl_t'(w);
        c.rsvd = '0;
        return c;
    endfunction

endpackage

// File: rtl/spi_byte_sync.sv
module spi_byte_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    generate
        if (STAGES <= 1) begin : g_single
            logic [W-1:0] stg_q;
            always_ff @(posedge clk) begin
                if (rst) stg_q <= RST_VAL;
                else     stg_q <= d_i;
            end
            assign q_o = stg_q;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] stg_q;
            always_ff @(posedge clk) begin
                if (rst) stg_q <= {STAGES{RST_VAL}};
                else     stg_q <= {stg_q[STAGES-2:0], d_i};
            end
            assign q_o = stg_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int FRAME_W  = 8,
    parameter int HALF_DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en_i,
    input  logic               mst_i,
    input  logic               sel_i,
    input  logic               load_i,
    input  logic [FRAME_W-1:0] load_data_i,
    input  logic               sck_s_i,
    input  logic               mosi_s_i,
    input  logic               miso_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [FRAME_W-1:0] shreg_o,
    output logic               sck_o
);

    localparam int CNT_W = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam int DIV_W = $clog2(HALF_DIV) + 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
    localparam logic [DIV_W-1:0] DIV_TOP  = DIV_W'(HALF_DIV - 1);

    logic               m_busy_q, s_act_q, sck_q, samp_q, sck_prev_q, done_q;
    logic [DIV_W-1:0]   div_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [FRAME_W-1:0] sh_q;
    logic               s_rise, s_fall;

    assign s_rise = sck_s_i & ~sck_prev_q;
    assign s_fall = ~sck_s_i & sck_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_busy_q   <= 1'b0;
            s_act_q    <= 1'b0;
            sck_q      <= 1'b0;
            samp_q     <= 1'b0;
            sck_prev_q <= 1'b0;
            done_q     <= 1'b0;
            div_q      <= '0;
            cnt_q      <= '0;
            sh_q       <= '0;
        end else begin
            done_q     <= 1'b0;
            sck_prev_q <= sck_s_i;
            if (en_i && mst_i) begin
                s_act_q <= 1'b0;
                if (!m_busy_q) begin
                    if (load_i) begin
                        sh_q     <= load_data_i;
                        m_busy_q <= 1'b1;
                        div_q    <= '0;
                        cnt_q    <= '0;
                        sck_q    <= 1'b0;
                    end
                end else if (div_q == DIV_TOP) begin
                    div_q <= '0;
                    sck_q <= ~sck_q;
                    if (!sck_q) begin
                        samp_q <= miso_i;
                    end else begin
                        sh_q <= {sh_q[FRAME_W-2:0], samp_q};
                        if (cnt_q == LAST_BIT) begin
                            m_busy_q <= 1'b0;
                            done_q   <= 1'b1;
                            cnt_q    <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end else begin
                m_busy_q <= 1'b0;
                sck_q    <= 1'b0;
                div_q    <= '0;
                if (load_i && !s_act_q) sh_q <= load_data_i;
                if (en_i && sel_i) begin
                    if (s_rise) begin
                        samp_q  <= mosi_s_i;
                        s_act_q <= 1'b1;
                    end else if (s_fall && s_act_q) begin
                        sh_q <= {sh_q[FRAME_W-2:0], samp_q};
                        if (cnt_q == LAST_BIT) begin
                            s_act_q <= 1'b0;
                            cnt_q   <= '0;
                            done_q  <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end else begin
                    s_act_q <= 1'b0;
                    cnt_q   <= '0;
                end
            end
        end
    end

    assign busy_o  = m_busy_q | s_act_q;
    assign done_o  = done_q;
    assign shreg_o = sh_q;
    assign sck_o   = sck_q;

    AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !m_busy_q |-> !sck_q); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R2

endmodule

// File: rtl/spi_byte_status.sv
module spi_byte_status
    import spi_byte_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stat_acc_i,
    input  logic               any_acc_i,
    input  logic               rd_rx_i,
    input  logic               wr_tx_i,
    input  logic               wr_ctrl_i,
    input  logic               done_i,
    input  logic [FRAME_W-1:0] rx_word_i,
    input  logic               busy_i,
    input  logic               modf_evt_i,
    output flags_t             flags_o,
    output logic [FRAME_W-1:0] rxbuf_o,
    output logic               tx_ok_o
);

    flags_t             fl_q;
    logic               arm_data_q, arm_modf_q;
    logic [FRAME_W-1:0] rxbuf_q;
    logic               clr_data, clr_modf;

    assign clr_data = arm_data_q & (rd_rx_i | wr_tx_i);
    assign clr_modf = arm_modf_q & wr_ctrl_i;
    assign tx_ok_o  = wr_tx_i & ~fl_q.done & ~busy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q       <= '0;
            arm_data_q <= 1'b0;
            arm_modf_q <= 1'b0;
            rxbuf_q    <= '0;
        end else begin
            if (stat_acc_i) begin
                arm_data_q <= 1'b1;
                arm_modf_q <= fl_q.modf;
            end else if (any_acc_i) begin
                arm_data_q <= 1'b0;
                arm_modf_q <= 1'b0;
            end

            if (done_i)        fl_q.done <= 1'b1;
            else if (clr_data) fl_q.done <= 1'b0;

            if (wr_tx_i && !fl_q.done && busy_i) fl_q.wcol <= 1'b1;
            else if (clr_data)                   fl_q.wcol <= 1'b0;

            if (done_i && fl_q.done) fl_q.ovr <= 1'b1;
            else if (clr_data)       fl_q.ovr <= 1'b0;

            if (modf_evt_i)    fl_q.modf <= 1'b1;
            else if (clr_modf) fl_q.modf <= 1'b0;

            if (done_i && !fl_q.done) rxbuf_q <= rx_word_i;
        end
    end

    assign flags_o = fl_q;
    assign rxbuf_o = rxbuf_q;

    AST_OVR_KEEPS_RX: assert property (@(posedge clk) disable iff (rst)
        (done_i && fl_q.done) |=> $stable(rxbuf_q)); // R6

    AST_OVR_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_q.ovr) |-> fl_q.done); // R6

endmodule

// File: rtl/spi_byte_port.sv
module spi_byte_port
    import spi_byte_pkg::*;
#(
    parameter int FRAME_W     = 8,
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             irq_o,
    input  logic             sck_i,
    output logic             sck_o,
    output logic             sck_oe,
    input  logic             mosi_i,
    output logic             mosi_o,
    output logic             mosi_oe,
    input  logic             miso_i,
    output logic             miso_o,
    output logic             miso_oe,
    input  logic             ss_n_i
);

    ctrl_t              ctrl_q;
    pinsel_t            pin_q;
    flags_t             flags;
    logic [2:0]         pin_s;
    logic               sck_s, mosi_s, ss_s;
    logic               ss_eff_n, sel, modf_evt, master_on;
    logic               any_acc, stat_acc, wr_ctrl, wr_stat, wr_tx, rd_rx;
    logic               tx_ok, busy, done;
    logic [FRAME_W-1:0] shreg, rxbuf;
    addr_e              addr;

    assign addr     = addr_e'(bus_addr);
    assign any_acc  = bus_wr | bus_rd;
    assign stat_acc = any_acc & (addr == A_STAT);
    assign wr_ctrl  = bus_wr & (addr == A_CTRL);
    assign wr_stat  = bus_wr & (addr == A_STAT);
    assign wr_tx    = bus_wr & (addr == A_TXD);
    assign rd_rx    = bus_rd & (addr == A_RXD);

    spi_byte_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i ({sck_i, mosi_i, ss_n_i}),
        .q_o (pin_s)
    );

    assign sck_s  = pin_s[2];
    assign mosi_s = pin_s[1];
    assign ss_s   = pin_s[0];

    assign ss_eff_n  = pin_q.ssm ? pin_q.ssi : ss_s;
    assign sel       = ~ss_eff_n;
    assign modf_evt  = ctrl_q.en & ctrl_q.mst & sel;
    assign master_on = ctrl_q.en & ctrl_q.mst;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pin_q  <= '0;
        end else begin
            if (wr_ctrl)  ctrl_q     <= ctrl_from_bus(bus_wdata);
            if (modf_evt) ctrl_q.mst <= 1'b0;
            if (wr_stat)  pin_q      <= pinsel_t'(bus_wdata[2:0]);
        end
    end

    spi_byte_shifter #(
        .FRAME_W  (FRAME_W),
        .HALF_DIV (HALF_DIV)
    ) shift_i (
        .clk         (clk),
        .rst         (rst),
        .en_i        (ctrl_q.en),
        .mst_i       (ctrl_q.mst),
        .sel_i       (sel),
        .load_i      (tx_ok),
        .load_data_i (bus_wdata[FRAME_W-1:0]),
        .sck_s_i     (sck_s),
        .mosi_s_i    (mosi_s),
        .miso_i      (miso_i),
        .busy_o      (busy),
        .done_o      (done),
        .shreg_o     (shreg),
        .sck_o       (sck_o)
    );

    spi_byte_status #(
        .FRAME_W (FRAME_W)
    ) stat_i (
        .clk        (clk),
        .rst        (rst),
        .stat_acc_i (stat_acc),
        .any_acc_i  (any_acc),
        .rd_rx_i    (rd_rx),
        .wr_tx_i    (wr_tx),
        .wr_ctrl_i  (wr_ctrl),
        .done_i     (done),
        .rx_word_i  (shreg),
        .busy_i     (busy),
        .modf_evt_i (modf_evt),
        .flags_o    (flags),
        .rxbuf_o    (rxbuf),
        .tx_ok_o    (tx_ok)
    );

    assign sck_oe  = master_on;
    assign mosi_o  = shreg[FRAME_W-1];
    assign mosi_oe = master_on & ~pin_q.sod;
    assign miso_o  = shreg[FRAME_W-1];
    assign miso_oe = ctrl_q.en & ~ctrl_q.mst & sel & ~pin_q.sod & ~flags.modf;
    assign irq_o   = ctrl_q.ie & (flags.done | flags.modf);

    always_comb begin
        case (addr)
            A_CTRL:  bus_rdata = ctrl_q;
            A_STAT:  bus_rdata = stat_word(flags, pin_q);
            A_RXD:   bus_rdata = REG_W'(rxbuf);
            default: bus_rdata = '0;
        endcase
    end

    AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        done |=> flags.done); // R2

    AST_MODF_DROPS_MASTER: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.modf) |-> !ctrl_q.mst); // R7

    AST_TX_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (wr_tx && flags.done && !busy) |=> !busy); // R4

    AST_WCOL_KEEPS_FRAME: assert property (@(posedge clk) disable iff (rst)
        (wr_tx && busy && ctrl_q.mst) |=> $stable(ctrl_q) || !busy); // R5

endmodule

// File: tb/spi_byte_port_tb.sv
module spi_byte_port_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       irq_o, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
    logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1, inv = 1'b0;
    logic       miso_i;

    int n_chk = 0, n_fail = 0, n_edge = 0;
    logic [7:0] cap = '0;
    logic       done_flag = 1'b0;

    always #5 clk = ~clk;

    assign miso_i = mosi_o ^ inv;

    spi_byte_port dut_i (
        .clk (clk), .rst (rst),
        .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .irq_o (irq_o),
        .sck_i (sck_i), .sck_o (sck_o), .sck_oe (sck_oe),
        .mosi_i (mosi_i), .mosi_o (mosi_o), .mosi_oe (mosi_oe),
        .miso_i (miso_i), .miso_o (miso_o), .miso_oe (miso_oe),
        .ss_n_i (ss_n_i)
    );

    always @(posedge sck_o) begin
        cap    <= {cap[6:0], mosi_o};
        n_edge <= n_edge + 1;
    end

    // {tx byte, invert loopback, expected receive byte}
    localparam logic [16:0] VEC [6] = '{
        {8'hA5, 1'b0, 8'hA5},
        {8'h3C, 1'b1, 8'hC3},
        {8'h00, 1'b0, 8'h00},
        {8'hFF, 1'b1, 8'h00},
        {8'h81, 1'b0, 8'h81},
        {8'h5A, 1'b1, 8'hA5}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_irq();
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (irq_o) break;
        end
    endtask

    task automatic slave_xfer(input logic [7:0] m, output logic [7:0] got);
        got = '0;
        for (int i = 7; i >= 0; i--) begin
            mosi_i = m[i];
            repeat (6) @(negedge clk);
            got = {got[6:0], miso_o};
            sck_i = 1'b1;
            repeat (6) @(negedge clk);
            sck_i = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd, got;
        int e0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        bus_read(2'd0, rd); chk("R12 ctrl", rd, 8'h00);
        bus_read(2'd1, rd); chk("R12 stat", rd, 8'h00);
        bus_read(2'd3, rd); chk("R12 rx", rd, 8'h00);
        chk("R12 outs", {4'b0, irq_o, sck_oe, mosi_oe, miso_oe}, 8'h00);

        // R1 R2 R3 master loopback table
        bus_write(2'd0, 8'h07);
        bus_write(2'd1, 8'h00);
        for (int v = 0; v < 6; v++) begin
            inv = VEC[v][8];
            bus_write(2'd2, VEC[v][16:9]);
            wait_irq();
            chk("R2 irq", {7'b0, irq_o}, 8'h01);
            chk("R1 mosi bits", cap, VEC[v][16:9]);
            bus_read(2'd1, rd); chk("R2 stat", rd, 8'h80);
            bus_read(2'd3, rd); chk("R1 rx", rd, VEC[v][7:0]);
            bus_read(2'd1, rd); chk("R3 cleared", rd, 8'h00);
            chk("R2 irq low", {7'b0, irq_o}, 8'h00);
        end
        inv = 1'b0;

        // R5 collision, then R4 blocked write
        bus_write(2'd2, 8'h96);
        repeat (20) @(negedge clk);
        bus_write(2'd2, 8'h11);
        wait_irq();
        chk("R5 frame intact", cap, 8'h96);
        e0 = n_edge;
        bus_write(2'd2, 8'h11);
        repeat (80) @(negedge clk);
        chk("R4 no sck", 8'(n_edge - e0), 8'h00);
        bus_read(2'd1, rd); chk("R5 wcol", rd, 8'hC0);
        bus_read(2'd3, rd); chk("R5 rx", rd, 8'h96);
        bus_read(2'd1, rd); chk("R3 wcol cleared", rd, 8'h00);

        // R9 master output disable
        bus_write(2'd1, 8'h04);
        chk("R9 master", {6'b0, sck_oe, mosi_oe}, 8'h02);
        bus_write(2'd1, 8'h00);
        chk("R9 master on", {6'b0, sck_oe, mosi_oe}, 8'h03);

        // R7 R8 mode fault
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        chk("R7 irq", {7'b0, irq_o}, 8'h01);
        chk("R7 outs off", {6'b0, sck_oe, mosi_oe}, 8'h00);
        bus_read(2'd0, rd); chk("R7 master cleared", rd, 8'h05);
        ss_n_i = 1'b1;
        bus_write(2'd0, 8'h05);
        bus_read(2'd1, rd); chk("R8 kept", rd, 8'h10);
        bus_write(2'd0, 8'h05);
        bus_read(2'd1, rd); chk("R8 cleared", rd, 8'h00);
        chk("R8 irq low", {7'b0, irq_o}, 8'h00);

        // R11 slave, R6 overrun, R3 broken sequence
        bus_write(2'd1, 8'h02);
        bus_write(2'd2, 8'h3C);
        chk("R10 selected", {7'b0, miso_oe}, 8'h01);
        slave_xfer(8'hA7, got);
        chk("R11 miso bits", got, 8'h3C);
        bus_read(2'd1, rd); chk("R2 slave stat", rd, 8'h82);
        bus_read(2'd0, rd);
        slave_xfer(8'h5E, got);
        bus_read(2'd1, rd); chk("R6 ovr", rd, 8'hA2);
        bus_read(2'd0, rd);
        bus_read(2'd3, rd); chk("R6 rx kept", rd, 8'hA7);
        bus_read(2'd1, rd);
        bus_write(2'd0, 8'h05);
        bus_read(2'd3, rd);
        bus_read(2'd1, rd); chk("R3 broken", rd, 8'hA2);
        bus_read(2'd3, rd);
        bus_read(2'd1, rd); chk("R3 slave cleared", rd, 8'h02);

        // R10 internal select
        bus_write(2'd1, 8'h03);
        bus_write(2'd2, 8'h55);
        slave_xfer(8'hFF, got);
        chk("R10 oe off", {7'b0, miso_oe}, 8'h00);
        bus_read(2'd1, rd); chk("R10 no frame", rd, 8'h03);
        bus_write(2'd1, 8'h06);
        chk("R9 slave", {7'b0, miso_oe}, 8'h00);
        bus_write(2'd1, 8'h02);
        slave_xfer(8'h12, got);
        chk("R11 miso after skip", got, 8'h55);
        bus_read(2'd1, rd); chk("R10 pin ignored", rd, 8'h82);
        bus_read(2'd3, rd); chk("R11 rx", rd, 8'h12);

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule